// File: doc/BRIEF.md
# ALU with Status Flags

A 16-bit arithmetic and logic unit for a small multi-cycle RISC core. It works in two-operand form: the destination operand is both the first input and the target, and the second input is taken from either a source register or an immediate. The unit does add, subtract, and, or, nor, compare, logical shift left and logical shift right. The result is combinational, so the core can capture it in the same cycle.

An 8-bit status register sits beside the datapath and holds carry, overflow, negative, zero, interrupt enable and a signed less-than flag that conditional branches read. Flags change on a clock edge when the flag-update enable is high. Compare writes no result. The interrupt-enable bit has its own write port, and no arithmetic or logic operation touches it.

Top module: `alu_status_unit`

## Requirements
- R1: `op_i` encodes add=0, sub=1, and=2, or=3, nor=4, cmp=5, shl=6, shr=7. Add and sub give `result_o` = (dst ± src) mod 2^16, combinationally in the same cycle.
- R2: and, or and nor give dst&src, dst|src and ~(dst|src) on `result_o`.
- R3: shl and shr are logical shifts of dst by the unsigned value of the selected source. A shift amount of 16 or more gives 0.
- R4: when `use_imm_i`=1 the source is `imm_i` and `rs_i` has no effect. When it is 0 the source is `rs_i`.
- R5: for cmp, `result_we_o`=0 and `result_o` equals dst. For every other operation `result_we_o`=1.
- R6: `status_o` bit layout is carry=bit0, overflow=bit1, negative=bit2, zero=bit3, interrupt enable=bit4, less-than=bit5. Bits 7:6 always read 0. Reset clears the whole register.
- R7: with `flag_en_i`=1, every operation loads negative (bit 15) and zero from its value: the result, or dst-src for cmp. Carry and overflow change only on add, sub and cmp; all other operations leave them unchanged.
- R8: carry is the unsigned carry-out on add, and no-borrow (dst ≥ src unsigned) on sub and cmp. Overflow is signed two's-complement overflow of the add or subtract.
- R9: less-than is loaded only by sub and cmp, with the signed result dst < src. Other operations leave it unchanged.
- R10: with `flag_en_i`=0, no ALU flag changes on the clock edge.
- R11: the interrupt-enable bit changes only when `ie_we_i`=1, and then takes `ie_i` at the next edge. A flag update in the same cycle changes the other flags as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation select |
| use_imm_i | input | 1 | Take the source from the immediate |
| dst_i | input | 16 | Destination operand (first input) |
| rs_i | input | 16 | Source register operand |
| imm_i | input | 16 | Immediate operand |
| flag_en_i | input | 1 | Load ALU flags at the clock edge |
| ie_we_i | input | 1 | Write interrupt enable |
| ie_i | input | 1 | Interrupt enable value to write |
| result_o | output | 16 | Operation result |
| result_we_o | output | 1 | Result should be written back |
| status_o | output | 8 | Status register |

## Verification
The interrupt-enable write and an ALU flag update can land on the same clock edge. They share one register, so one must not overwrite the other. The sweep turns on `ie_we_i` on a fixed cadence while the flag enable stays high on most operations. This produces both same-edge writes and writes alone. After each edge, bit 4 is compared against the value written, and the carry, overflow, sign, zero and less-than bits are compared against a bench model updated from the operation.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int STATUS_W = 8;
  localparam int FLAG_C   = 0;
  localparam int FLAG_O   = 1;
  localparam int FLAG_N   = 2;
  localparam int FLAG_Z   = 3;
  localparam int FLAG_IE  = 4;
  localparam int FLAG_LT  = 5;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_NOR = 3'd4,
    OP_CMP = 3'd5,
    OP_SHL = 3'd6,
    OP_SHR = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic o;
    logic n;
    logic z;
    logic lt;
    logic upd_co;
    logic upd_lt;
  } alu_flags_t;
endpackage

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic [WIDTH-1:0] amt_i,
  input  logic             left_i,
  output logic [WIDTH-1:0] res_o
);
  localparam int SHW = $clog2(WIDTH);

  logic             in_range;
  logic [SHW-1:0]   sh;

  assign in_range = (amt_i < WIDTH[WIDTH-1:0]);
  assign sh       = amt_i[SHW-1:0];

  always_comb begin
    if (!in_range)   res_o = '0;
    else if (left_i) res_o = val_i << sh;
    else             res_o = val_i >> sh;
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o,
  output logic             we_o,
  output alu_flags_t       flags_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   sum;
  logic [WIDTH:0]   diff;
  logic [WIDTH-1:0] sh_res;
  logic [WIDTH-1:0] flag_src;
  logic             ovf_add;
  logic             ovf_sub;

  assign sum     = {1'b0, a_i} + {1'b0, b_i};
  assign diff    = {1'b0, a_i} - {1'b0, b_i};
  assign ovf_add = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);
  assign ovf_sub = (a_i[MSB] != b_i[MSB]) && (diff[MSB] != a_i[MSB]);

  alu_shifter #(.WIDTH(WIDTH)) u_shift (
    .val_i (a_i),
    .amt_i (b_i),
    .left_i(op_i == OP_SHL),
    .res_o (sh_res)
  );

  always_comb begin
    we_o = 1'b1;
    unique case (op_i)
      OP_ADD:        res_o = sum[MSB:0];
      OP_SUB:        res_o = diff[MSB:0];
      OP_AND:        res_o = a_i & b_i;
      OP_OR:         res_o = a_i | b_i;
      OP_NOR:        res_o = ~(a_i | b_i);
      OP_CMP: begin  res_o = a_i; we_o = 1'b0; end
      OP_SHL, OP_SHR: res_o = sh_res;
      default:       res_o = '0;
    endcase
  end

  // compare sets sign/zero from the difference it discards
  assign flag_src = (op_i == OP_CMP) ? diff[MSB:0] : res_o;

  always_comb begin
    flags_o.n      = flag_src[MSB];
    flags_o.z      = (flag_src == '0);
    flags_o.upd_co = (op_i == OP_ADD) || (op_i == OP_SUB) || (op_i == OP_CMP);
    flags_o.upd_lt = (op_i == OP_SUB) || (op_i == OP_CMP);
    flags_o.c      = (op_i == OP_ADD) ? sum[WIDTH] : ~diff[WIDTH];
    flags_o.o      = (op_i == OP_ADD) ? ovf_add : ovf_sub;
    flags_o.lt     = diff[MSB] ^ ovf_sub;
  end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
  import alu_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flag_en_i,
  input  alu_flags_t          flags_i,
  input  logic                ie_we_i,
  input  logic                ie_i,
  output logic [STATUS_W-1:0] status_o
);
  logic c_q, o_q, n_q, z_q, ie_q, lt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q <= 1'b0; o_q <= 1'b0; n_q <= 1'b0;
      z_q <= 1'b0; ie_q <= 1'b0; lt_q <= 1'b0;
    end else begin
      if (flag_en_i) begin
        n_q <= flags_i.n;
        z_q <= flags_i.z;
        if (flags_i.upd_co) begin
          c_q <= flags_i.c;
          o_q <= flags_i.o;
        end
        if (flags_i.upd_lt) lt_q <= flags_i.lt;
      end
      if (ie_we_i) ie_q <= ie_i;
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[FLAG_C]  = c_q;
    status_o[FLAG_O]  = o_q;
    status_o[FLAG_N]  = n_q;
    status_o[FLAG_Z]  = z_q;
    status_o[FLAG_IE] = ie_q;
    status_o[FLAG_LT] = lt_q;
  end

  assert_ie_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_we_i |=> $stable(status_o[FLAG_IE]));
  assert_ie_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_we_i |=> status_o[FLAG_IE] == $past(ie_i));
  assert_no_flag_change_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_en_i && !ie_we_i) |=> $stable(status_o));
  assert_co_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_i.upd_co |=> $stable(status_o[FLAG_O:FLAG_C]));
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          op_i,
  input  logic                use_imm_i,
  input  logic [WIDTH-1:0]    dst_i,
  input  logic [WIDTH-1:0]    rs_i,
  input  logic [WIDTH-1:0]    imm_i,
  input  logic                flag_en_i,
  input  logic                ie_we_i,
  input  logic                ie_i,
  output logic [WIDTH-1:0]    result_o,
  output logic                result_we_o,
  output logic [STATUS_W-1:0] status_o
);
  alu_op_e          op;
  logic [WIDTH-1:0] src;
  alu_flags_t       flags;

  assign op  = alu_op_e'(op_i);
  assign src = use_imm_i ? imm_i : rs_i;

  alu_core #(.WIDTH(WIDTH)) u_core (
    .op_i   (op),
    .a_i    (dst_i),
    .b_i    (src),
    .res_o  (result_o),
    .we_o   (result_we_o),
    .flags_o(flags)
  );

  alu_status_reg u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flag_en_i(flag_en_i),
    .flags_i  (flags),
    .ie_we_i  (ie_we_i),
    .ie_i     (ie_i),
    .status_o (status_o)
  );

  assert_sub_carry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && (op == OP_SUB || op == OP_CMP))
      |=> status_o[FLAG_C] == ($past(dst_i) >= $past(src)));
  assert_cmp_keeps_dst_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_CMP) |-> (!result_we_o && result_o == dst_i));
endmodule

// File: tb/test_alu_status_unit.sv
module test_alu_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = '0;
  logic        use_imm = 1'b0;
  logic [15:0] dst = '0, rs = '0, imm = '0;
  logic        flag_en = 1'b0, ie_we = 1'b0, ie_v = 1'b0;
  logic [15:0] result;
  logic        result_we;
  logic [7:0]  status;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  alu_status_unit i_alu_status_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .use_imm_i(use_imm),
    .dst_i(dst), .rs_i(rs), .imm_i(imm), .flag_en_i(flag_en),
    .ie_we_i(ie_we), .ie_i(ie_v), .result_o(result),
    .result_we_o(result_we), .status_o(status)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s op=%0d dst=%h src=%h actual=%h expected=%h", req, op, dst, use_imm ? imm : rs, act, exp);
    end
  endtask

  function automatic logic [15:0] pick(input int i);
    case (i)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;
      3: return 16'h000F;  4: return 16'h0010;  5: return 16'h0011;
      6: return 16'h7FFF;  7: return 16'h8000;  8: return 16'h8001;
      9: return 16'hFFFF;  10: return 16'hFFFE; 11: return 16'h5555;
      12: return 16'hAAAA; default: return 16'h1234;
    endcase
  endfunction

  logic [7:0] st_m;

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k;
    k = 0;
    repeat (3) @(posedge clk);
    #1;
    check(status == 8'h00, "R6", {8'h0, status}, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    st_m = 8'h00;
    for (int o = 0; o < 8; o++) begin
      for (int ui = 0; ui < 2; ui++) begin
        for (int ia = 0; ia < 14; ia++) begin
          for (int ib = 0; ib < 14; ib++) begin
            logic [15:0] a, b, er;
            logic [16:0] s, d;
            logic        ewe, ov_a, ov_s;
            logic [15:0] fsrc;
            string       rq;
            @(negedge clk);
            k++;
            op = 3'(o); use_imm = ui[0]; dst = pick(ia);
            if (ui == 1) begin imm = pick(ib); rs = ~pick(ib); end
            else begin rs = pick(ib); imm = ~pick(ib); end
            flag_en = (k % 7) != 3;
            ie_we   = (k % 5) == 0;
            ie_v    = (k / 5) % 2 == 1;
            a = dst; b = pick(ib);
            s = {1'b0, a} + {1'b0, b};
            d = {1'b0, a} - {1'b0, b};
            ov_a = (a[15] == b[15]) && (s[15] != a[15]);
            ov_s = (a[15] != b[15]) && (d[15] != a[15]);
            ewe = 1'b1;
            case (o)
              0: begin er = s[15:0]; rq = "R1"; end
              1: begin er = d[15:0]; rq = "R1"; end
              2: begin er = a & b; rq = "R2"; end
              3: begin er = a | b; rq = "R2"; end
              4: begin er = ~(a | b); rq = "R2"; end
              5: begin er = a; ewe = 1'b0; rq = "R5"; end
              6: begin er = (b >= 16) ? 16'h0 : 16'(a << b[3:0]); rq = "R3"; end
              default: begin er = (b >= 16) ? 16'h0 : 16'(a >> b[3:0]); rq = "R3"; end
            endcase
            #1;
            check(result == er, rq, result, er);
            if (ui == 1) check(result == er, "R4", result, er);
            check(result_we == ewe, "R5", {15'h0, result_we}, {15'h0, ewe});
            // bench model of the status register
            if (flag_en) begin
              fsrc = (o == 5) ? d[15:0] : er;
              st_m[2] = fsrc[15];
              st_m[3] = (fsrc == 16'h0);
              if (o == 0) begin st_m[0] = s[16]; st_m[1] = ov_a; end
              if (o == 1 || o == 5) begin
                st_m[0] = (a >= b); st_m[1] = ov_s;
                st_m[5] = $signed(a) < $signed(b);
              end
            end
            if (ie_we) st_m[4] = ie_v;
            @(posedge clk);
            #1;
            check(status[1:0] == st_m[1:0], "R8", {8'h0, status}, {8'h0, st_m});
            check(status[3:2] == st_m[3:2], "R7", {8'h0, status}, {8'h0, st_m});
            check(status[5] == st_m[5], "R9", {8'h0, status}, {8'h0, st_m});
            check(status[4] == st_m[4], "R11", {8'h0, status}, {8'h0, st_m});
            check(status[7:6] == 2'b00, "R6", {8'h0, status}, {8'h0, st_m});
            if (!flag_en) check(status == st_m, "R10", {8'h0, status}, {8'h0, st_m});
          end
        end
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule